// File: doc/BRIEF.md
# Synchronous SRAM Write and Select Control

This block is the control core of a synchronous static RAM with registered inputs and a flow-through read path. On each rising clock edge it decides whether the device is selected and which 9-bit lanes of the addressed word get written. It then writes those lanes into a small parameterised array and latches the address and cycle state. Read data leaves the array combinationally from the latched address, with no output register. Each lane holds eight data bits and one parity bit.

Three select inputs of mixed polarity enable the device. A global write input stores the whole word and wins over everything else. A byte-write gate either passes the per-lane write strobes through or blocks them. While the output enable is active and the last cycle was a selected read, an output-valid flag stands in for the tristate pad driver. Any write in a cycle forces that flag off. The output enable works without the clock. A sleep input freezes all state and keeps the array contents.

The data path is a plain pin-level memory port: there is no valid/ready handshake and no back-pressure. A write always completes on the edge where it is presented. Read data is meaningful whenever `rvalid_o` is high.

Top module: `sram_wsel_ctl`

## Requirements
- R1: The device is selected on an edge only when `en_n_i`=0, `sel_hi_i`=1 and `sel_lo_n_i`=0. On any other combination nothing is written, and `rvalid_o` is low after that edge.
- R2: If the device is selected, not sleeping, and `gwr_n_i`=0 on an edge, every lane of the addressed word takes `wdata_i`, whatever the values of `bgate_n_i` and `bwr_n_i`.
- R3: If `gwr_n_i`=1 and `bgate_n_i`=0 on a selected edge, lane k is written only when `bwr_n_i[k]`=0. Lane k is bits 9k+8..9k of the word: bits 9k..9k+7 are data and bit 9k+8 is its parity. The other lanes keep their contents.
- R4: If `gwr_n_i`=1 and `bgate_n_i`=1, `bwr_n_i` is ignored and no lane is written.
- R5: After an edge that wrote any lane, `rvalid_o` is low until the next edge.
- R6: `rvalid_o` is high only when the last edge was a selected read, `oe_n_i`=0 and `sleep_i`=0. A change on `oe_n_i` reaches `rvalid_o` without any clock edge.
- R7: After each active edge, `rdata_o` equals the word stored at the address presented on that edge, including data written on that same edge.
- R8: While `sleep_i`=1 on an edge, neither the array nor the latched address or cycle state changes, and `rvalid_o` stays low.
- R9: Asserting `rst_n` low clears the latched select and write state, so `rvalid_o` goes low at once. Array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the cycle state |
| addr_i | input | ADDR_W | Word address, taken on the edge |
| wdata_i | input | 9*NLANES | Write data, 9 bits per lane |
| en_n_i | input | 1 | Active-low enable select |
| sel_hi_i | input | 1 | Active-high select |
| sel_lo_n_i | input | 1 | Active-low select |
| gwr_n_i | input | 1 | Active-low whole-word write |
| bgate_n_i | input | 1 | Active-low gate for the lane strobes |
| bwr_n_i | input | NLANES | Active-low per-lane write strobes |
| oe_n_i | input | 1 | Active-low asynchronous output enable |
| sleep_i | input | 1 | High freezes all state |
| rdata_o | output | 9*NLANES | Flow-through word at the latched address |
| rvalid_o | output | 1 | Output-driven flag that replaces the tristate |

## Verification
The hardest state to reach from the ports is a sleep edge that carries a complete, otherwise valid write to a different address. Only then does a failure of the freeze show up, as a change in either the array or the latched address. The bench first reads one word so that the latched address is known. It then raises `sleep_i` and drives a global write of zeros to a second address. While still asleep it checks that `rdata_o` shows the first word. After waking, it reads the second word back unchanged. Reset retention is checked the same way: a word is written before a mid-run reset and read back after it.

// File: rtl/sram_wsel_pkg.sv
package sram_wsel_pkg;
  // width of one lane: eight data bits plus one parity bit
  localparam int LANE_W = 9;

  // cycle state latched on every active edge
  typedef struct packed {
    logic sel;
    logic wr;
  } cyc_state_t;
endpackage

// File: rtl/sram_sel_dec.sv
module sram_sel_dec (
  input  logic en_n,
  input  logic sel_hi,
  input  logic sel_lo_n,
  output logic sel
);
  // three-input select of mixed polarity
  assign sel = ~en_n & sel_hi & ~sel_lo_n;
endmodule

// File: rtl/sram_wmask_dec.sv
module sram_wmask_dec #(
  parameter int NLANES = 2
) (
  input  logic              sel,
  input  logic              gwr_n,
  input  logic              bgate_n,
  input  logic [NLANES-1:0] bwr_n,
  output logic [NLANES-1:0] mask,
  output logic              any_wr
);
  logic [NLANES-1:0] lane_req;

  always_comb begin
    if (!gwr_n)        lane_req = '1;      // whole word wins
    else if (!bgate_n) lane_req = ~bwr_n;  // strobes passed through
    else               lane_req = '0;      // strobes blocked
  end

  assign mask   = sel ? lane_req : '0;
  assign any_wr = |mask;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_wsel_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NLANES = 2
) (
  input  logic                     clk,
  input  logic                     tick,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [NLANES*LANE_W-1:0] wdata,
  input  logic [NLANES-1:0]        mask,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [NLANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
      if (tick && mask[g]) mem_q[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    // flow-through: no output register
    assign rdata[g*LANE_W +: LANE_W] = mem_q[raddr];
  end
endmodule

// File: rtl/sram_out_gate.sv
module sram_out_gate
  import sram_wsel_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sel,
  input  logic              any_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rvalid
);
  cyc_state_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      st_q   <= '0;
    end else if (tick) begin
      addr_q <= addr;
      st_q   <= '{sel: sel, wr: any_wr};
    end
  end

  assign rvalid = st_q.sel & ~st_q.wr & ~oe_n & ~sleep;

  // R5
  wr_kills_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && any_wr) |=> !rvalid);
endmodule

// File: rtl/sram_wsel_ctl.sv
module sram_wsel_ctl
  import sram_wsel_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NLANES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NLANES*LANE_W-1:0] wdata_i,
  input  logic                     en_n_i,
  input  logic                     sel_hi_i,
  input  logic                     sel_lo_n_i,
  input  logic                     gwr_n_i,
  input  logic                     bgate_n_i,
  input  logic [NLANES-1:0]        bwr_n_i,
  input  logic                     oe_n_i,
  input  logic                     sleep_i,
  output logic [NLANES*LANE_W-1:0] rdata_o,
  output logic                     rvalid_o
);
  logic              sel;
  logic [NLANES-1:0] mask;
  logic              any_wr;
  logic              tick;
  logic [ADDR_W-1:0] addr_q;

  assign tick = ~sleep_i;

  sram_sel_dec u_sel (
    .en_n(en_n_i), .sel_hi(sel_hi_i), .sel_lo_n(sel_lo_n_i), .sel(sel)
  );

  sram_wmask_dec #(.NLANES(NLANES)) u_wmask (
    .sel(sel), .gwr_n(gwr_n_i), .bgate_n(bgate_n_i), .bwr_n(bwr_n_i),
    .mask(mask), .any_wr(any_wr)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .NLANES(NLANES)) u_array (
    .clk(clk), .tick(tick), .waddr(addr_i), .wdata(wdata_i), .mask(mask),
    .raddr(addr_q), .rdata(rdata_o)
  );

  sram_out_gate #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .any_wr(any_wr),
    .addr(addr_i), .oe_n(oe_n_i), .sleep(sleep_i), .addr_q(addr_q),
    .rvalid(rvalid_o)
  );

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && (en_n_i || !sel_hi_i || sel_lo_n_i)) |=> !rvalid_o);

  // R2
  gw_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !en_n_i && sel_hi_i && !sel_lo_n_i && !gwr_n_i)
      |=> (rdata_o == $past(wdata_i)));

  // R8
  sleep_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> $stable(rdata_o));

  // R8
  sleep_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !rvalid_o);
endmodule

// File: tb/sram_wsel_ctl_bench.sv
module sram_wsel_ctl_bench;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int NL = 2;
  localparam int DW = NL * 9;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [2:0]    cs;   // {en_n, sel_hi, sel_lo_n}; 3'b010 selects
    logic          gw;
    logic          bg;
    logic [NL-1:0] bw;
    logic          oe;
    logic          ev;   // expected rvalid after the edge
  } vec_t;

  localparam int VW = $bits(vec_t);
  localparam int NV = 13;
  localparam logic [VW-1:0] VT [NV] = '{
    {4'd1, 18'h2A5A5, 3'b010, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0}, // R2 R5
    {4'd1, 18'h00000, 3'b010, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1}, // R4 bw ignored
    {4'd2, 18'h15555, 3'b010, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R2 gw over gate
    {4'd2, 18'h3FFFF, 3'b010, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0}, // R3 lane0
    {4'd2, 18'h00000, 3'b010, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1}, // R3 readback
    {4'd2, 18'h00000, 3'b010, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0}, // R3 lane1
    {4'd2, 18'h3FFFF, 3'b010, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1}, // R3 readback
    {4'd3, 18'h0AAAA, 3'b010, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0}, // R7 write-through
    {4'd3, 18'h12345, 3'b110, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R1 en_n high
    {4'd3, 18'h12345, 3'b011, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R1 sel_lo_n high
    {4'd3, 18'h12345, 3'b000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R1 sel_hi low
    {4'd3, 18'h00000, 3'b010, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0}, // R6 oe high
    {4'd3, 18'h00000, 3'b010, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1}  // R6 oe low
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic en_n = 1'b1, sel_hi = 1'b0, sel_lo_n = 1'b1;
  logic gwr_n = 1'b1, bgate_n = 1'b1;
  logic [NL-1:0] bwr_n = '1;
  logic oe_n = 1'b1, sleep = 1'b0;
  logic [DW-1:0] rdata;
  logic rvalid;

  int total = 0, bad = 0;
  logic [DW-1:0] ref_mem [1<<AW];

  always #(CLK_P/2) clk = ~clk;

  sram_wsel_ctl #(.ADDR_W(AW), .NLANES(NL)) u_sram_wsel_ctl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .en_n_i(en_n), .sel_hi_i(sel_hi), .sel_lo_n_i(sel_lo_n),
    .gwr_n_i(gwr_n), .bgate_n_i(bgate_n), .bwr_n_i(bwr_n),
    .oe_n_i(oe_n), .sleep_i(sleep), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model of the write rules, applied when inputs are driven
  task automatic model_edge();
    logic s;
    logic [NL-1:0] m;
    s = (!en_n && sel_hi && !sel_lo_n);
    m = !gwr_n ? '1 : (!bgate_n ? ~bwr_n : '0);
    if (s && !sleep)
      for (int k = 0; k < NL; k++)
        if (m[k]) ref_mem[addr][k*9 +: 9] = wdata[k*9 +: 9];
  endtask

  task automatic drive(input vec_t v);
    addr = v.a; wdata = v.d; {en_n, sel_hi, sel_lo_n} = v.cs;
    gwr_n = v.gw; bgate_n = v.bg; bwr_n = v.bw; oe_n = v.oe;
    model_edge();
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R9 reset rvalid", {17'd0, rvalid}, '0);
    rst_n = 1'b1;

    // preload every word so no read touches unwritten storage
    for (int i = 0; i < (1<<AW); i++) begin
      @(negedge clk);
      drive('{a: AW'(i), d: '0, cs: 3'b010, gw: 1'b0, bg: 1'b1, bw: '1,
              oe: 1'b1, ev: 1'b0});
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      v = vec_t'(VT[i]);
      drive(v);
      @(negedge clk);
      check($sformatf("R7 vec%0d rdata", i), rdata, ref_mem[v.a]);
      check($sformatf("R1/R5/R6 vec%0d rvalid", i), {17'd0, rvalid},
            {17'd0, v.ev});
    end

    // R6: output enable acts without a clock edge (addr 3, selected read)
    oe_n = 1'b1; #1;
    check("R6 oe async off", {17'd0, rvalid}, '0);
    oe_n = 1'b0; #1;
    check("R6 oe async on", {17'd0, rvalid}, 18'd1);

    // R8: read addr 1, then sleep while a full write to addr 2 is presented
    @(negedge clk);
    drive('{a: 4'd1, d: '0, cs: 3'b010, gw: 1'b1, bg: 1'b1, bw: '1,
            oe: 1'b0, ev: 1'b1});
    @(negedge clk);
    sleep = 1'b1;
    drive('{a: 4'd2, d: 18'h00000, cs: 3'b010, gw: 1'b0, bg: 1'b1, bw: '1,
            oe: 1'b0, ev: 1'b0});
    #1;
    check("R8 sleep rvalid low", {17'd0, rvalid}, '0);
    @(negedge clk);
    check("R8 latched addr frozen", rdata, ref_mem[1]);
    sleep = 1'b0;
    drive('{a: 4'd2, d: '0, cs: 3'b010, gw: 1'b1, bg: 1'b1, bw: '1,
            oe: 1'b0, ev: 1'b1});
    @(negedge clk);
    check("R8 array untouched", rdata, 18'h3FFFF & ref_mem[2]);
    check("R8 wake rvalid", {17'd0, rvalid}, 18'd1);

    // R9: reset clears output state at once, array retained
    rst_n = 1'b0; #1;
    check("R9 async reset rvalid", {17'd0, rvalid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    drive('{a: 4'd1, d: '0, cs: 3'b010, gw: 1'b1, bg: 1'b1, bw: '1,
            oe: 1'b0, ev: 1'b1});
    @(negedge clk);
    check("R9 data retained", rdata, 18'h2A5A5);
    check("R9 read after reset", {17'd0, rvalid}, 18'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule